// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This unit decides whether a conditional-trap instruction fires. It compares two register operands once and works out five relations in parallel: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. A 5-bit condition mask from the instruction picks any subset of these relations. A trap is requested when at least one picked relation holds.

Two operand widths are supported. The doubleword form compares all 64 bits. The word form compares only the low 32 bits and treats bit 31 as the sign. The trap request, the per-relation hit vector and the program-exception sub-cause code are all registered. They appear one clock after the valid strobe and remain zero in any cycle that follows a cycle without the strobe.

Top module: `trap_compare_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) selects signed less-than: A < B with both operands read as two's complement.
- R2: Mask bit 3 (0x08) selects signed greater-than, and mask bit 2 (0x04) selects equality.
- R3: Mask bit 1 (0x02) selects unsigned less-than, and mask bit 0 (0x01) selects unsigned greater-than.
- R4: The relations are ORed. `trap_o` is 1 exactly when the hit vector `hit_o` is nonzero. `hit_o` is the bitwise AND of the mask and the relation vector, using the same bit positions as the mask.
- R5: With `dword_i`=0 (word form), only bits 31:0 of each operand take part and bit 31 is the sign. Bits 63:32 have no effect on any output.
- R6: With `dword_i`=1 (doubleword form), all 64 bits take part and bit 63 is the sign.
- R7: A mask of 0 never traps, whatever the operands are.
- R8: A mask of 0x1F always traps, because exactly one of the signed relations (less-than, greater-than, equal) always holds.
- R9: The outputs reflect the inputs sampled at the clock edge where `valid_i` is 1. After an edge where `valid_i` is 0, `trap_o`, `hit_o` and `cause_o` are all zero.
- R10: `cause_o` carries the trap sub-cause code 4'h2 when `trap_o` is 1, and 4'h0 otherwise.
- R11: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and mask are valid this cycle |
| dword_i | input | 1 | 1: 64-bit compare, 0: low 32-bit compare |
| mask_i | input | 5 | Condition select mask, bit 4 to bit 0: slt, sgt, eq, ult, ugt |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| trap_o | output | 1 | Registered trap request |
| hit_o | output | 5 | Registered selected relations that held |
| cause_o | output | 4 | Registered program-exception sub-cause |

## Verification
Several properties are checked on every cycle. In each compare slice, exactly one of the signed relations and exactly one of the unsigned relations holds. A trap never follows a cycle without a strobe. A zero mask never traps and a full mask always traps. `trap_o` agrees with `hit_o`, and `cause_o` agrees with `trap_o`. What only the bench scenarios can show is that each relation is decided correctly at the sign and width boundaries. These boundaries include an operand that is negative as a word but positive as a doubleword, and upper halves that differ while the low words match.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;
  localparam int unsigned XLEN     = 64;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_REL    = 5;
  localparam int unsigned CAUSE_W  = 4;
  localparam logic [CAUSE_W-1:0] TRAP_CAUSE = 4'h2;

  // bit order matches the condition mask: [4]slt [3]sgt [2]eq [1]ult [0]ugt
  typedef struct packed {
    logic lt_s;
    logic gt_s;
    logic eq;
    logic lt_u;
    logic gt_u;
  } rel_t;
endpackage

// File: rtl/trap_rel_cmp.sv
module trap_rel_cmp
  import trap_cmp_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output rel_t         rel_o
);
  logic eq, lt_u, lt_s;

  assign eq   = (a_i == b_i);
  assign lt_u = (a_i < b_i);
  assign lt_s = ($signed(a_i) < $signed(b_i));

  always_comb begin
    rel_o.eq   = eq;
    rel_o.lt_u = lt_u;
    rel_o.gt_u = !lt_u && !eq;
    rel_o.lt_s = lt_s;
    rel_o.gt_s = !lt_s && !eq;
  end

  assert_signed_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rel_o.lt_s, rel_o.gt_s, rel_o.eq}) == 1);
  assert_unsigned_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rel_o.lt_u, rel_o.gt_u, rel_o.eq}) == 1);
endmodule

// File: rtl/trap_cond_sel.sv
module trap_cond_sel
  import trap_cmp_pkg::*;
(
  input  logic [N_REL-1:0] mask_i,
  input  rel_t             rel_i,
  output logic [N_REL-1:0] hit_o,
  output logic             fire_o
);
  logic [N_REL-1:0] rel_vec;
  assign rel_vec = rel_i;

  for (genvar i = 0; i < N_REL; i++) begin : g_hit
    assign hit_o[i] = mask_i[i] & rel_vec[i];
  end

  assign fire_o = |(mask_i & rel_vec);
endmodule

// File: rtl/trap_compare_unit.sv
module trap_compare_unit
  import trap_cmp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                dword_i,
  input  logic [N_REL-1:0]    mask_i,
  input  logic [XLEN-1:0]     opa_i,
  input  logic [XLEN-1:0]     opb_i,
  output logic                trap_o,
  output logic [N_REL-1:0]    hit_o,
  output logic [CAUSE_W-1:0]  cause_o
);
  localparam int unsigned N_WIDTHS = 2;
  localparam int unsigned W_IDX    = 0;
  localparam int unsigned D_IDX    = 1;

  rel_t rel_w [N_WIDTHS];
  rel_t rel_sel;

  // one compare slice per supported width
  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_slice
    localparam int unsigned SW = (g == D_IDX) ? XLEN : WORD_W;
    trap_rel_cmp #(.W(SW)) u_cmp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (opa_i[SW-1:0]),
      .b_i   (opb_i[SW-1:0]),
      .rel_o (rel_w[g])
    );
  end

  assign rel_sel = dword_i ? rel_w[D_IDX] : rel_w[W_IDX];

  logic [N_REL-1:0] hit_d;
  logic             fire_d;

  trap_cond_sel u_sel (
    .mask_i(mask_i),
    .rel_i (rel_sel),
    .hit_o (hit_d),
    .fire_o(fire_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o  <= 1'b0;
      hit_o   <= '0;
      cause_o <= '0;
    end else begin
      trap_o  <= valid_i & fire_d;
      hit_o   <= valid_i ? hit_d : '0;
      cause_o <= (valid_i & fire_d) ? TRAP_CAUSE : '0;
    end
  end

  assert_no_trap_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!trap_o && hit_o == '0 && cause_o == '0));
  assert_zero_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_i == '0) |=> !trap_o);
  assert_full_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_i == '1) |=> trap_o);
  assert_trap_hit_agree_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o == (hit_o != '0));
  assert_cause_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o == (trap_o ? TRAP_CAUSE : '0));
  assert_hit_in_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((hit_o & ~$past(mask_i)) == '0));
endmodule

// File: tb/trap_compare_unit_tb.sv
module trap_compare_unit_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYCLES = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        dword_i = 1'b0;
  logic [4:0]  mask_i = '0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic        trap_o;
  logic [4:0]  hit_o;
  logic [3:0]  cause_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trap_compare_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .dword_i(dword_i),
    .mask_i(mask_i), .opa_i(opa_i), .opb_i(opb_i),
    .trap_o(trap_o), .hit_o(hit_o), .cause_o(cause_o)
  );

  typedef struct {
    logic       trap;
    logic [4:0] hit;
    logic [3:0] cause;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   mon_en   = 0;
  bit   done     = 0;

  function automatic logic [4:0] rel_model(logic [63:0] a, logic [63:0] b, logic dw);
    logic [63:0] sa, sb, ua, ub;
    logic slt, sgt, e, ult, ugt;
    if (dw) begin
      sa = a; sb = b; ua = a; ub = b;
    end else begin
      sa = {{32{a[31]}}, a[31:0]}; sb = {{32{b[31]}}, b[31:0]};
      ua = {32'h0, a[31:0]};       ub = {32'h0, b[31:0]};
    end
    slt = $signed(sa) < $signed(sb);
    sgt = $signed(sa) > $signed(sb);
    e   = (ua == ub);
    ult = ua < ub;
    ugt = ua > ub;
    return {slt, sgt, e, ult, ugt};
  endfunction

  task automatic drive(input logic v, input logic dw, input logic [4:0] m,
                       input logic [63:0] a, input logic [63:0] b, input string req);
    exp_t e;
    @(negedge clk_i);
    valid_i = v; dword_i = dw; mask_i = m; opa_i = a; opb_i = b;
    e.hit   = v ? (m & rel_model(a, b, dw)) : 5'h0;
    e.trap  = (e.hit != 0);
    e.cause = e.trap ? 4'h2 : 4'h0;
    e.req   = req;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (mon_en && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_checks++;
        if (trap_o !== e.trap || hit_o !== e.hit || cause_o !== e.cause) begin
          n_fail++;
          $display("FAIL %s: trap/hit/cause actual %b/%h/%h expected %b/%h/%h",
                   e.req, trap_o, hit_o, cause_o, e.trap, e.hit, e.cause);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (WDOG_CYCLES) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    // R11: reset state
    repeat (3) @(negedge clk_i);
    n_checks++;
    if (trap_o !== 1'b0 || hit_o !== 5'h0 || cause_o !== 4'h0) begin
      n_fail++;
      $display("FAIL R11: actual %b/%h/%h expected 0/00/0", trap_o, hit_o, cause_o);
    end
    rst_ni = 1'b1;
    mon_en = 1;

    // R1 signed lt, doubleword
    drive(1, 1, 5'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R1");
    // R3 same operands: unsigned lt false, unsigned gt true
    drive(1, 1, 5'h02, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R3");
    drive(1, 1, 5'h01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R3");
    // R2 signed gt and equality
    drive(1, 1, 5'h08, 64'h5, 64'hFFFF_FFFF_FFFF_FFF0, "R2");
    drive(1, 1, 5'h04, 64'hDEAD_BEEF_0000_1234, 64'hDEAD_BEEF_0000_1234, "R2");
    drive(1, 1, 5'h04, 64'hDEAD_BEEF_0000_1234, 64'hDEAD_BEEF_0000_1235, "R2");
    // R4 OR of several, including a mask whose relations all fail
    drive(1, 1, 5'h18, 64'h77, 64'h77, "R4");
    drive(1, 1, 5'h16, 64'h3, 64'h9, "R4");
    // R5 word form: upper halves differ, low words equal
    drive(1, 0, 5'h04, 64'h1234_5678_0000_0005, 64'hABCD_0000_0000_0005, "R5");
    drive(1, 1, 5'h04, 64'h1234_5678_0000_0005, 64'hABCD_0000_0000_0005, "R6");
    // R5/R6 sign at bit 31 versus bit 63
    drive(1, 0, 5'h10, 64'h0000_0000_8000_0000, 64'h1, "R5");
    drive(1, 1, 5'h10, 64'h0000_0000_8000_0000, 64'h1, "R6");
    drive(1, 0, 5'h01, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, "R5");
    // R7 zero mask
    drive(1, 1, 5'h00, 64'h1, 64'h2, "R7");
    drive(1, 0, 5'h00, 64'h9, 64'h9, "R7");
    // R8 full mask
    drive(1, 1, 5'h1F, 64'h42, 64'h42, "R8");
    drive(1, 0, 5'h1F, 64'h8000_0000_0000_0000, 64'h0, "R8");
    // R9 no strobe: full mask must not trap
    drive(0, 1, 5'h1F, 64'h1, 64'h2, "R9");
    drive(1, 1, 5'h10, 64'h1, 64'h2, "R9");
    drive(0, 0, 5'h1F, 64'h0, 64'h0, "R9");
    // R10 cause code on mixed stream
    for (int i = 0; i < 60; i++) begin
      logic [63:0] a, b;
      a = {$urandom(), $urandom()};
      b = (i % 4 == 0) ? a : {$urandom(), $urandom()};
      if (i % 5 == 1) b[31:0] = a[31:0];
      drive((i % 7) != 3, i[0], 5'($urandom()), a, b, "R10");
    end
    drive(0, 0, 5'h0, 64'h0, 64'h0, "R9");
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule